// File: doc/BRIEF.md
# Genlock Frame Line Counter

This block keeps the line and pixel position of a video output stream. With nothing driving it from outside it counts freely: pixels run from 0 to the programmed line length minus one, and lines run from 1 up to the programmed frame length and then start again at 1. When the output acts as a timing slave and genlock is switched on, an external frame-sync pin can pull this count into line with another source.

The sync pin first crosses into the pixel clock domain through a two-flop synchroniser. Its active transition, rising or falling by a select bit, then waits a programmable number of pixel clocks. When that wait ends, the line counter takes a preset line number and the pixel counter restarts at 0. A one-cycle resync flag reports the load only when it actually moved the count. An edge that falls where the free-running count already expects it leaves the output timing untouched. Set the delay to one line length minus the synchroniser latency and the preset to 2; an edge that arrives at the end of a frame then continues the stream at line 2 with no step in timing.

Top module: `genlock_line_counter`

## Requirements
- R1: While reset is held, the line number reads 1, the line-start strobe is high (pixel 0) and the resync flag is low.
- R2: When free running, the pixel position advances by one each clock from 0 to line_len-1. line_start is high exactly at pixel 0. The line number steps by one at each line start and goes from frame_len back to 1. line_len must be at least 2.
- R3: Transitions on the sync pin have no effect while sync_master is 1 or genlock_en is 0.
- R4: fsync_rise_sel = 1 makes the 0-to-1 transition of the sync pin active and fsync_rise_sel = 0 makes the 1-to-0 transition active. The other transition is ignored.
- R5: With delay D in slave_dly, an active transition applied between clock edges loads the counters on the (3+D)th rising clock edge after it. After that edge the line number equals frame_preset (1 to frame_len) and the pixel position is 0.
- R6: The resync flag is high for exactly the one cycle that follows a load, and only when the loaded line/pixel differ from what free running would have produced at that edge. At all other times it is low.
- R7: An active transition that arrives while an earlier delay is still counting cancels the earlier one, and only the newer one causes a load.
- R8: Take slave_dly = line_len-2 and frame_preset = 2, with the active transition applied during the last pixel of the last line. The stream then continues with no change in timing and no resync.
- R9: With slave_dly = 0 the load happens on the third rising clock edge after the active transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_master | input | 1 | 1: block is timing master, sync pin ignored |
| genlock_en | input | 1 | 1: lock to the sync pin when not master |
| fsync_in | input | 1 | External frame-sync pin, asynchronous |
| fsync_rise_sel | input | 1 | 1: rising transition active, 0: falling |
| slave_dly | input | DLY_W | Pixel clocks between the synchronised edge and the load |
| frame_preset | input | LINE_W | Line number loaded by a delayed edge |
| frame_len | input | LINE_W | Last line number of a frame |
| line_len | input | PIX_W | Pixels per line |
| line_num | output | LINE_W | Current line number, 1-based |
| line_start | output | 1 | High during pixel 0 of each line |
| resync | output | 1 | One-cycle pulse when a load changed the count |

## Verification
The bench builds the block with LINE_W = 4, PIX_W = 4 and DLY_W = 6, and programs a 6-pixel, 5-line frame. A whole frame is then only 30 cycles, so every cycle of several frames is compared with a position computed by modular arithmetic. Each load is placed arithmetically at its expected edge. Short frames and small delays make it possible to time an edge to land exactly on the free-running position, to restart a pending delay, to use zero delay, and to load presets at both ends of the frame, all within a few hundred cycles.

// File: rtl/gl_pkg.sv
// Shared types for the genlock line counter.
// Assumes nothing beyond a synthesizable target.
package gl_pkg;

    // State of the slave delay counter.
    typedef enum logic {
        DLY_IDLE = 1'b0,
        DLY_RUN  = 1'b1
    } dly_state_t;

endpackage

// File: rtl/gl_edge_detect.sv
// Synchronises the asynchronous frame-sync pin into the pixel clock domain
// and produces a one-cycle pulse on the selected transition.
// Assumes the pin stays at each level for at least one clock period.
module gl_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic rise_sel,
    output logic edge_pulse
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the pin through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-2:0], pin_async};
        end
    end

    // Compare the newest synchronised sample with the one before it.
    always_comb begin
        if (rise_sel) begin
            edge_pulse = chain[CHAIN_W-2] & ~chain[CHAIN_W-1];
        end else begin
            edge_pulse = ~chain[CHAIN_W-2] & chain[CHAIN_W-1];
        end
    end

endmodule

// File: rtl/gl_edge_delay.sv
// Holds back a synchronised edge for a programmable number of clocks, then
// issues a one-cycle fire pulse. A new edge restarts the wait; zero delay
// fires in the edge cycle itself.
// Assumes delay is held steady while a wait is in progress.
module gl_edge_delay #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             edge_in,
    input  logic [DLY_W-1:0] delay,
    output logic             fire
);
    import gl_pkg::*;

    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    dly_state_t       state;
    logic [DLY_W-1:0] remain;
    logic             zero_dly;
    logic             wait_done;

    // Decide when the held edge is released.
    always_comb begin
        zero_dly  = (delay == '0);
        wait_done = (state == DLY_RUN) && (remain == ONE) && !edge_in;
        fire      = enable && ((edge_in && zero_dly) || wait_done);
    end

    // Load, count down and retire the pending wait.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state  <= DLY_IDLE;
            remain <= '0;
        end else if (edge_in) begin
            remain <= delay;
            state  <= zero_dly ? DLY_IDLE : DLY_RUN;
        end else if (state == DLY_RUN) begin
            remain <= remain - ONE;
            if (remain == ONE) begin
                state <= DLY_IDLE;
            end
        end
    end

endmodule

// File: rtl/gl_line_timer.sv
// Pixel and line counters for one video frame. They run freely and accept a
// load of (preset line, pixel 0). After a load they flag for one cycle
// whether the load moved the count.
// Assumes line_len >= 2 and 1 <= preset <= frame_len.
module gl_line_timer #(
    parameter int LINE_W = 11,
    parameter int PIX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] preset,
    input  logic [LINE_W-1:0] frame_len,
    input  logic [PIX_W-1:0]  line_len,
    output logic [LINE_W-1:0] line_q,
    output logic              sol,
    output logic              moved
);
    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);
    localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);

    logic [PIX_W-1:0]  pix_q;
    logic [PIX_W-1:0]  pix_nxt;
    logic [LINE_W-1:0] line_nxt;
    logic              last_pix;

    // Free-running successor of the current position.
    always_comb begin
        last_pix = (pix_q >= line_len - PIX_ONE);
        pix_nxt  = last_pix ? '0 : pix_q + PIX_ONE;
        if (!last_pix) begin
            line_nxt = line_q;
        end else if (line_q >= frame_len) begin
            line_nxt = LINE_ONE;
        end else begin
            line_nxt = line_q + LINE_ONE;
        end
    end

    // Advance the position, or take the preset and flag any jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= LINE_ONE;
            pix_q  <= '0;
            moved  <= 1'b0;
        end else if (load) begin
            line_q <= preset;
            pix_q  <= '0;
            moved  <= (preset != line_nxt) || (pix_nxt != '0);
        end else begin
            line_q <= line_nxt;
            pix_q  <= pix_nxt;
            moved  <= 1'b0;
        end
    end

    // Mark the first pixel of each line.
    always_comb sol = (pix_q == '0);

endmodule

// File: rtl/genlock_line_counter.sv
// Video output line counter that can lock to an external frame-sync pin.
// Genlock acts only when the block is not master and genlock is enabled.
// Pin-to-load latency is SYNC_STAGES + 1 + slave_dly clocks.
// Assumes line_len >= 2 and 1 <= frame_preset <= frame_len.
module genlock_line_counter #(
    parameter int LINE_W      = 11,
    parameter int PIX_W       = 12,
    parameter int DLY_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_master,
    input  logic              genlock_en,
    input  logic              fsync_in,
    input  logic              fsync_rise_sel,
    input  logic [DLY_W-1:0]  slave_dly,
    input  logic [LINE_W-1:0] frame_preset,
    input  logic [LINE_W-1:0] frame_len,
    input  logic [PIX_W-1:0]  line_len,
    output logic [LINE_W-1:0] line_num,
    output logic              line_start,
    output logic              resync
);
    logic lock_active;
    logic sync_edge;
    logic gated_edge;
    logic load_now;

    // Genlock is live only as a timing slave with the feature switched on.
    always_comb begin
        lock_active = !sync_master && genlock_en;
        gated_edge  = sync_edge && lock_active;
    end

    gl_edge_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (fsync_in),
        .rise_sel   (fsync_rise_sel),
        .edge_pulse (sync_edge)
    );

    gl_edge_delay #(
        .DLY_W(DLY_W)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (lock_active),
        .edge_in (gated_edge),
        .delay   (slave_dly),
        .fire    (load_now)
    );

    gl_line_timer #(
        .LINE_W(LINE_W),
        .PIX_W (PIX_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_now),
        .preset    (frame_preset),
        .frame_len (frame_len),
        .line_len  (line_len),
        .line_q    (line_num),
        .sol       (line_start),
        .moved     (resync)
    );

endmodule

// File: rtl/gl_checker.sv
// Temporal checks on the genlock line counter ports, bound to the top.
// Assumes frame_len is not changed during operation.
module gl_checker #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_master,
    input logic              genlock_en,
    input logic [LINE_W-1:0] frame_len,
    input logic [LINE_W-1:0] line_num,
    input logic              line_start,
    input logic              resync
);
    // R6: a load pulse never lasts two cycles.
    p_resync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !resync);

    // R3: no resync follows a cycle spent as master.
    p_ignore_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_master |=> !resync);

    // R3: no resync follows a cycle with genlock off.
    p_ignore_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !genlock_en |=> !resync);

    // R2: an undisturbed line start moves the line number up by one.
    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !resync && line_num != LINE_W'(1) && $past(rst_n))
        |-> (line_num == LINE_W'($past(line_num) + LINE_W'(1))));

    // R2: an undisturbed return to line 1 comes only from the last line.
    p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !resync && line_num == LINE_W'(1) && $past(rst_n))
        |-> ($past(line_num) >= frame_len));

endmodule

bind genlock_line_counter gl_checker #(
    .LINE_W(LINE_W)
) u_gl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_master (sync_master),
    .genlock_en  (genlock_en),
    .frame_len   (frame_len),
    .line_num    (line_num),
    .line_start  (line_start),
    .resync      (resync)
);

// File: tb/genlock_line_counter_test.sv
`timescale 1ns/1ps
// Self-checking bench: every cycle is compared with a frame position
// computed arithmetically from the cycle count and the scheduled loads.
module genlock_line_counter_test;
    localparam int LW = 4;
    localparam int PW = 4;
    localparam int DW = 6;
    localparam int LL = 6;
    localparam int FL = 5;
    localparam int T  = LL * FL;
    localparam int LAT = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          master = 1'b0;
    logic          gen_en = 1'b1;
    logic          fsync = 1'b0;
    logic          rise_sel = 1'b1;
    logic [DW-1:0] dly = DW'(4);
    logic [LW-1:0] preset = LW'(3);
    logic [LW-1:0] flen = LW'(FL);
    logic [PW-1:0] llen = PW'(LL);
    logic [LW-1:0] line_num;
    logic          line_start;
    logic          resync;

    genlock_line_counter #(
        .LINE_W(LW), .PIX_W(PW), .DLY_W(DW), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sync_master(master), .genlock_en(gen_en),
        .fsync_in(fsync), .fsync_rise_sel(rise_sel), .slave_dly(dly),
        .frame_preset(preset), .frame_len(flen), .line_len(llen),
        .line_num(line_num), .line_start(line_start), .resync(resync)
    );

    int    cnt = 0;
    int    bn = 0, bpos = 0, pbn = 0, pbpos = 0;
    int    rs_n = -1;
    bit    rs_exp = 1'b0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string req = "R1";
    int    checks = 0, fails = 0;

    always @(posedge clk) if (rst_n) cnt <= cnt + 1;

    function automatic int pos_at(int n);
        if (n >= bn) return (bpos + n - bn) % T;
        return (pbpos + n - pbn) % T;
    endfunction

    task automatic chk(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at count %0d: actual %0d expected %0d", r, what, cnt, act, exp);
        end
    endtask

    // Per-cycle comparison against the arithmetic model.
    always @(negedge clk) begin
        if (checking) begin
            automatic int p = pos_at(cnt);
            automatic int er = (cnt == rs_n) ? int'(rs_exp) : 0;
            chk(req, "line_num", int'(line_num), p / LL + 1);
            chk(req, "line_start", int'(line_start), int'(p % LL == 0));
            chk((cnt == rs_n) ? "R6" : req, "resync", int'(resync), er);
        end
    end

    // R5: record where an active transition applied now will load.
    task automatic sched(int d, int pre);
        automatic int ln = cnt + LAT + d;
        automatic int np = (pre - 1) * LL;
        rs_exp = (pos_at(ln) != np);
        rs_n   = ln;
        pbn = bn; pbpos = bpos;
        bn = ln; bpos = np;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        // R1: reset state
        chk("R1", "line_num", int'(line_num), 1);
        chk("R1", "line_start", int'(line_start), 1);
        chk("R1", "resync", int'(resync), 0);
        rst_n = 1'b1;
        checking = 1'b1;

        req = "R2"; cyc(70);

        // R5/R6: mismatched edge, delay 4, preset 3
        req = "R5"; dly = DW'(4); preset = LW'(3);
        cyc(7);
        fsync = 1'b1; sched(4, 3);
        cyc(3); fsync = 1'b0;
        cyc(40);

        // R8: edge in the last pixel of the frame, delay LL-2, preset 2
        req = "R8"; dly = DW'(LL - 2); preset = LW'(2);
        while (pos_at(cnt) != T - 1) @(negedge clk);
        fsync = 1'b1; sched(LL - 2, 2);
        if (rs_exp) begin
            fails++;
            $display("FAIL R8 model: actual 1 expected 0");
        end
        cyc(3); fsync = 1'b0;
        cyc(40);

        // R4: falling polarity; rising transition must be ignored
        req = "R4"; rise_sel = 1'b0; dly = DW'(3); preset = LW'(5);
        cyc(5);
        fsync = 1'b1; cyc(20);
        fsync = 1'b0; sched(3, 5);
        cyc(40);
        rise_sel = 1'b1; cyc(5);

        // R3: master mode ignores the pin
        req = "R3"; master = 1'b1; cyc(3);
        fsync = 1'b1; cyc(4); fsync = 1'b0; cyc(30);
        master = 1'b0; cyc(5);
        // R3: genlock disabled ignores the pin
        gen_en = 1'b0; cyc(3);
        fsync = 1'b1; cyc(4); fsync = 1'b0; cyc(30);
        gen_en = 1'b1; cyc(5);

        // R7: second edge restarts a pending delay of 8
        req = "R7"; dly = DW'(8); preset = LW'(4);
        cyc(3);
        fsync = 1'b1; cyc(2);
        fsync = 1'b0; cyc(2);
        fsync = 1'b1; sched(8, 4); cyc(2);
        fsync = 1'b0;
        cyc(40);

        // R9: zero delay, preset 1
        req = "R9"; dly = DW'(0); preset = LW'(1);
        cyc(11);
        fsync = 1'b1; sched(0, 1);
        cyc(3); fsync = 1'b0;
        cyc(40);

        // R5: preset at the last line with delay 1
        req = "R5"; dly = DW'(1); preset = LW'(FL);
        cyc(4);
        fsync = 1'b1; sched(1, FL);
        cyc(3); fsync = 1'b0;
        cyc(40);

        checking = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule